// File: doc/BRIEF.md
# Data-Ready Triggered ADC Frame Reader

This block is the SPI host for a multichannel delta-sigma converter. The converter announces each new conversion with a falling edge on an active-low data-ready line. After reset the block brings the converter up with a fixed command sequence. It sends an unlock command, then a list of register writes set by parameters. It then enables every ADC channel and sends a wakeup command. Each command is confirmed by reading back the converter's acknowledge word, and a step whose acknowledge does not match is sent again.

Once startup is complete, each high-to-low transition of data-ready starts one data frame. Chip select stays low for the whole frame. The host sends a null command and reads one status word, one word per channel and an optional CRC word. It places the status and the sign-extended 24-bit samples on a valid/ready output. A new data-ready edge that arrives while a frame is still being read sets a sticky overrun flag.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset the block sends these commands in order: unlock 0x0655, then one write per configured register with the command {3'b010, addr[4:0], data[7:0]}, then the write of 0x0F to address 0x0F, then wakeup 0x0033. Each command goes in bits 31:16 of a one-word frame, with bits 15:0 zero. Each command frame is followed by a one-word frame that sends the null command 0x0000 and reads the acknowledge.
- R2: The expected acknowledge, read from bits 31:16, is 0x0655 for unlock, {3'b001, addr[4:0], data[7:0]} for a register write and 0x0033 for wakeup. On a mismatch the same command and its acknowledge read are repeated before the block moves to the next step.
- R3: A data frame starts only on a high-to-low transition of `drdy_n_i` after startup has finished. A low level held without a transition starts no frame, and transitions seen during startup are ignored.
- R4: A data frame is 1 + NUM_CH + CRC_EN words of WORD_W bits each. Chip select is held low for the whole frame and is driven high between frames.
- R5: Every bit sent on MOSI during a data frame is zero, so the first word is the null command and the later words are zero fill.
- R6: SCLK is low whenever chip select is high. MOSI changes only while SCLK is low. MISO is sampled on each rising SCLK edge, most significant bit first.
- R7: `m_status_o` carries bits 31:16 of the first word of the frame.
- R8: Channel c (0-based) of `m_samples_o[c*OUT_W +: OUT_W]` carries bits 31:8 of word c+1, sign-extended to OUT_W. The low 8 bits of each word are ignored.
- R9: `m_valid_o` rises when a frame completes and stays high with unchanged data until `m_ready_i` is seen high. If a later frame completes first, its data replaces the held data.
- R10: A data-ready falling edge seen while a data frame is in progress sets `overrun_o`. The flag stays set until reset, and that edge starts no frame.
- R11: During reset, chip select is high, SCLK is low, and `m_valid_o` and `overrun_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| drdy_n_i | input | 1 | Active-low data-ready from converter (asynchronous) |
| sclk_o | output | 1 | SPI clock, idles low |
| cs_n_o | output | 1 | SPI chip select, active low |
| mosi_o | output | 1 | SPI data to converter |
| miso_i | input | 1 | SPI data from converter |
| m_valid_o | output | 1 | Frame output valid |
| m_ready_i | input | 1 | Frame output accepted |
| m_status_o | output | 16 | Status word of the frame |
| m_samples_o | output | NUM_CH*OUT_W | Sign-extended channel samples, channel 0 in the low slice |
| overrun_o | output | 1 | Sticky missed-frame flag |

## Verification
If the startup step counter or the acknowledge compare is wrong, the command stream on MOSI goes wrong. The error shows up within one or two command frames as a wrong, missing or unrepeated command word. If the word counter or the edge detector is wrong, the error shows up in the first data frame after startup. The chip-select window then holds the wrong number of words, or frames start without a transition, or held-low data-ready starts frames. A wrong data path shows up at `m_valid_o` of the same frame as a wrong status or sample value. A bad sign extension shows in the upper sample bits of any negative sample. Overrun handling is seen one frame later, as a flag that stays low or as an extra frame.

// File: rtl/adc_rdr_pkg.sv
package adc_rdr_pkg;

    localparam logic [15:0] CMD_NULL   = 16'h0000;
    localparam logic [15:0] CMD_UNLOCK = 16'h0655;
    localparam logic [15:0] CMD_WAKEUP = 16'h0033;
    localparam logic [7:0]  ENA_ADDR   = 8'h0F;
    localparam logic [7:0]  ENA_ALL    = 8'h0F;

    typedef enum logic [2:0] {
        RD_BOOT_CMD,
        RD_BOOT_CMD_WAIT,
        RD_BOOT_ACK,
        RD_BOOT_ACK_WAIT,
        RD_IDLE,
        RD_FRAME
    } rdr_state_e;

    typedef enum logic [2:0] {
        SP_IDLE,
        SP_SETUP,
        SP_LOW,
        SP_HIGH,
        SP_HOLD,
        SP_GAP
    } spi_state_e;

    function automatic logic [15:0] wr_cmd(input logic [7:0] addr, input logic [7:0] data);
        return {3'b010, addr[4:0], data};
    endfunction

    function automatic logic [15:0] wr_ack(input logic [7:0] addr, input logic [7:0] data);
        return {3'b001, addr[4:0], data};
    endfunction

endpackage

// File: rtl/adc_rdr_drdy_sync.sv
module adc_rdr_drdy_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic drdy_n_i,
    output logic fall_o
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[SH_W-2:0], drdy_n_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign fall_o = sh_q[SH_W-1] & ~sh_q[SH_W-2];
endmodule

// File: rtl/adc_rdr_boot_rom.sv
module adc_rdr_boot_rom
    import adc_rdr_pkg::*;
#(
    parameter int              NUM_CFG  = 3,
    parameter logic [NUM_CFG*8-1:0] CFG_ADDR = 24'h0E0D0B,
    parameter logic [NUM_CFG*8-1:0] CFG_DATA = 24'h800220,
    parameter int              STEP_W   = 3
) (
    input  logic [STEP_W-1:0] step_i,
    output logic [15:0]       cmd_o,
    output logic [15:0]       ack_o
);
    always_comb begin
        cmd_o = CMD_WAKEUP;
        ack_o = CMD_WAKEUP;
        if (step_i == '0) begin
            cmd_o = CMD_UNLOCK;
            ack_o = CMD_UNLOCK;
        end else if (int'(step_i) == NUM_CFG + 1) begin
            cmd_o = wr_cmd(ENA_ADDR, ENA_ALL);
            ack_o = wr_ack(ENA_ADDR, ENA_ALL);
        end else begin
            for (int i = 0; i < NUM_CFG; i++) begin
                if (int'(step_i) == i + 1) begin
                    cmd_o = wr_cmd(CFG_ADDR[i*8 +: 8], CFG_DATA[i*8 +: 8]);
                    ack_o = wr_ack(CFG_ADDR[i*8 +: 8], CFG_DATA[i*8 +: 8]);
                end
            end
        end
    end
endmodule

// File: rtl/adc_rdr_spi_frame.sv
module adc_rdr_spi_frame
    import adc_rdr_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int DIV       = 2,
    parameter int MAX_WORDS = 3,
    parameter int NW_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [15:0]       cmd_i,
    input  logic [NW_W-1:0]   nwords_i,
    output logic              word_valid_o,
    output logic [NW_W-1:0]   word_idx_o,
    output logic [WORD_W-1:0] word_o,
    output logic              done_o,
    output logic              sclk_o,
    output logic              cs_n_o,
    output logic              mosi_o,
    input  logic              miso_i
);
    localparam int CNT_W = $clog2(DIV + 1);
    localparam int BIT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(DIV - 1);
    localparam logic [BIT_W-1:0] BIT_END = BIT_W'(WORD_W - 1);

    typedef struct packed {
        spi_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [BIT_W-1:0]  bitc;
        logic [NW_W-1:0]   widx;
        logic [NW_W-1:0]   nw;
        logic [WORD_W-1:0] txsh;
        logic [WORD_W-1:0] rxsh;
        logic              sclk;
        logic              cs_n;
        logic              wvalid;
        logic [NW_W-1:0]   wout_idx;
        logic [WORD_W-1:0] wout;
        logic              done;
    } spi_regs_t;

    spi_regs_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        r_d.wvalid = 1'b0;
        r_d.done   = 1'b0;
        unique case (r_q.st)
            SP_IDLE: begin
                if (start_i) begin
                    r_d.cs_n = 1'b0;
                    r_d.txsh = {cmd_i, {(WORD_W-16){1'b0}}};
                    r_d.nw   = nwords_i;
                    r_d.widx = '0;
                    r_d.bitc = '0;
                    r_d.cnt  = '0;
                    r_d.st   = SP_SETUP;
                end
            end
            SP_SETUP: begin
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == CNT_END) begin
                    r_d.cnt = '0;
                    r_d.st  = SP_LOW;
                end
            end
            SP_LOW: begin
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == CNT_END) begin
                    r_d.cnt  = '0;
                    r_d.sclk = 1'b1;
                    r_d.rxsh = {r_q.rxsh[WORD_W-2:0], miso_i};
                    r_d.st   = SP_HIGH;
                end
            end
            SP_HIGH: begin
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == CNT_END) begin
                    r_d.cnt  = '0;
                    r_d.sclk = 1'b0;
                    r_d.txsh = {r_q.txsh[WORD_W-2:0], 1'b0};
                    r_d.st   = SP_LOW;
                    if (r_q.bitc == BIT_END) begin
                        r_d.bitc     = '0;
                        r_d.wvalid   = 1'b1;
                        r_d.wout     = r_q.rxsh;
                        r_d.wout_idx = r_q.widx;
                        if (r_q.widx == r_q.nw - 1'b1) r_d.st = SP_HOLD;
                        else                           r_d.widx = r_q.widx + 1'b1;
                    end else begin
                        r_d.bitc = r_q.bitc + 1'b1;
                    end
                end
            end
            SP_HOLD: begin
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == CNT_END) begin
                    r_d.cnt  = '0;
                    r_d.cs_n = 1'b1;
                    r_d.st   = SP_GAP;
                end
            end
            SP_GAP: begin
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == CNT_END) begin
                    r_d.cnt  = '0;
                    r_d.done = 1'b1;
                    r_d.st   = SP_IDLE;
                end
            end
            default: r_d.st = SP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= SP_IDLE;
            r_q.cs_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign word_valid_o = r_q.wvalid;
    assign word_idx_o   = r_q.wout_idx;
    assign word_o       = r_q.wout;
    assign done_o       = r_q.done;
    assign sclk_o       = r_q.sclk;
    assign cs_n_o       = r_q.cs_n;
    assign mosi_o       = r_q.txsh[WORD_W-1] & ~r_q.cs_n;
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
    import adc_rdr_pkg::*;
#(
    parameter int NUM_CH    = 2,
    parameter int CRC_EN    = 0,
    parameter int WORD_W    = 32,
    parameter int SAMPLE_W  = 24,
    parameter int OUT_W     = 32,
    parameter int SCLK_DIV  = 2,
    parameter int NUM_CFG   = 3,
    parameter logic [NUM_CFG*8-1:0] CFG_ADDR = 24'h0E0D0B,
    parameter logic [NUM_CFG*8-1:0] CFG_DATA = 24'h800220
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    drdy_n_i,
    output logic                    sclk_o,
    output logic                    cs_n_o,
    output logic                    mosi_o,
    input  logic                    miso_i,
    output logic                    m_valid_o,
    input  logic                    m_ready_i,
    output logic [15:0]             m_status_o,
    output logic [NUM_CH*OUT_W-1:0] m_samples_o,
    output logic                    overrun_o
);
    localparam int FRAME_WORDS = 1 + NUM_CH + CRC_EN;
    localparam int NUM_STEPS   = NUM_CFG + 3;
    localparam int STEP_W      = $clog2(NUM_STEPS);
    localparam int NW_W        = $clog2(FRAME_WORDS + 1);
    localparam int EXT_W       = OUT_W - SAMPLE_W;
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

    typedef struct packed {
        rdr_state_e              st;
        logic [STEP_W-1:0]       step;
        logic                    ack_ok;
        logic [15:0]             stat_buf;
        logic [NUM_CH*OUT_W-1:0] samp_buf;
        logic [15:0]             out_stat;
        logic [NUM_CH*OUT_W-1:0] out_samp;
        logic                    out_valid;
        logic                    ovr;
    } rdr_regs_t;

    rdr_regs_t r_d, r_q;

    logic              drdy_fall;
    logic [15:0]       rom_cmd, rom_ack;
    logic              sp_start;
    logic [15:0]       sp_cmd;
    logic [NW_W-1:0]   sp_nwords;
    logic              sp_wvalid, sp_done;
    logic [NW_W-1:0]   sp_widx;
    logic [WORD_W-1:0] sp_word;
    logic              unused_low_bits;

    assign unused_low_bits = ^sp_word[WORD_W-SAMPLE_W-1:0];

    adc_rdr_drdy_sync #(.SYNC_STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .drdy_n_i (drdy_n_i),
        .fall_o   (drdy_fall)
    );

    adc_rdr_boot_rom #(
        .NUM_CFG  (NUM_CFG),
        .CFG_ADDR (CFG_ADDR),
        .CFG_DATA (CFG_DATA),
        .STEP_W   (STEP_W)
    ) u_rom (
        .step_i (r_q.step),
        .cmd_o  (rom_cmd),
        .ack_o  (rom_ack)
    );

    adc_rdr_spi_frame #(
        .WORD_W    (WORD_W),
        .DIV       (SCLK_DIV),
        .MAX_WORDS (FRAME_WORDS),
        .NW_W      (NW_W)
    ) u_spi (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (sp_start),
        .cmd_i        (sp_cmd),
        .nwords_i     (sp_nwords),
        .word_valid_o (sp_wvalid),
        .word_idx_o   (sp_widx),
        .word_o       (sp_word),
        .done_o       (sp_done),
        .sclk_o       (sclk_o),
        .cs_n_o       (cs_n_o),
        .mosi_o       (mosi_o),
        .miso_i       (miso_i)
    );

    always_comb begin
        r_d       = r_q;
        sp_start  = 1'b0;
        sp_cmd    = CMD_NULL;
        sp_nwords = NW_W'(1);

        if (r_q.out_valid && m_ready_i) r_d.out_valid = 1'b0;

        unique case (r_q.st)
            RD_BOOT_CMD: begin
                sp_start = 1'b1;
                sp_cmd   = rom_cmd;
                r_d.st   = RD_BOOT_CMD_WAIT;
            end
            RD_BOOT_CMD_WAIT: begin
                if (sp_done) r_d.st = RD_BOOT_ACK;
            end
            RD_BOOT_ACK: begin
                sp_start = 1'b1;
                r_d.st   = RD_BOOT_ACK_WAIT;
            end
            RD_BOOT_ACK_WAIT: begin
                if (sp_wvalid) r_d.ack_ok = (sp_word[WORD_W-1 -: 16] == rom_ack);
                if (sp_done) begin
                    if (!r_q.ack_ok) begin
                        r_d.st = RD_BOOT_CMD;
                    end else if (r_q.step == LAST_STEP) begin
                        r_d.st = RD_IDLE;
                    end else begin
                        r_d.step = r_q.step + 1'b1;
                        r_d.st   = RD_BOOT_CMD;
                    end
                end
            end
            RD_IDLE: begin
                if (drdy_fall) begin
                    sp_start  = 1'b1;
                    sp_nwords = NW_W'(FRAME_WORDS);
                    r_d.st    = RD_FRAME;
                end
            end
            RD_FRAME: begin
                if (drdy_fall) r_d.ovr = 1'b1;
                if (sp_wvalid) begin
                    if (sp_widx == '0) r_d.stat_buf = sp_word[WORD_W-1 -: 16];
                    for (int c = 0; c < NUM_CH; c++) begin
                        if (int'(sp_widx) == c + 1) begin
                            r_d.samp_buf[c*OUT_W +: OUT_W] =
                                {{EXT_W{sp_word[WORD_W-1]}}, sp_word[WORD_W-1 -: SAMPLE_W]};
                        end
                    end
                end
                if (sp_done) begin
                    r_d.out_stat  = r_q.stat_buf;
                    r_d.out_samp  = r_q.samp_buf;
                    r_d.out_valid = 1'b1;
                    r_d.st        = RD_IDLE;
                end
            end
            default: r_d.st = RD_BOOT_CMD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= RD_BOOT_CMD;
        end else begin
            r_q <= r_d;
        end
    end

    assign m_valid_o   = r_q.out_valid;
    assign m_status_o  = r_q.out_stat;
    assign m_samples_o = r_q.out_samp;
    assign overrun_o   = r_q.ovr;
endmodule

// File: rtl/adc_rdr_checker.sv
module adc_rdr_checker #(
    parameter int NUM_CH   = 2,
    parameter int OUT_W    = 32,
    parameter int SAMPLE_W = 24
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    sclk,
    input logic                    cs_n,
    input logic                    mosi,
    input logic                    m_valid,
    input logic                    m_ready,
    input logic [NUM_CH*OUT_W-1:0] m_samples,
    input logic                    overrun
);
    localparam int TOP_W = OUT_W - SAMPLE_W + 1;

    assert_sclk_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    assert_mosi_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    assert_valid_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> m_valid);

    assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_sext
        assert_sign_ext_R8: assert property (@(posedge clk) disable iff (!rst_n)
            m_valid |-> (m_samples[c*OUT_W+SAMPLE_W-1 +: TOP_W] == '0 ||
                         m_samples[c*OUT_W+SAMPLE_W-1 +: TOP_W] == '1));
    end
endmodule

bind adc_frame_reader adc_rdr_checker #(
    .NUM_CH   (NUM_CH),
    .OUT_W    (OUT_W),
    .SAMPLE_W (SAMPLE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk      (sclk_o),
    .cs_n      (cs_n_o),
    .mosi      (mosi_o),
    .m_valid   (m_valid_o),
    .m_ready   (m_ready_i),
    .m_samples (m_samples_o),
    .overrun   (overrun_o)
);

// File: tb/adc_frame_reader_tb.sv
module adc_frame_reader_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic drdy_n = 1'b0;
    logic miso;
    logic m_ready = 1'b0;
    logic sclk, cs_n, mosi, m_valid, overrun;
    logic [15:0] m_status;
    logic [63:0] m_samples;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    adc_frame_reader u_dut (
        .clk (clk), .rst_n (rst_n), .drdy_n_i (drdy_n),
        .sclk_o (sclk), .cs_n_o (cs_n), .mosi_o (mosi), .miso_i (miso),
        .m_valid_o (m_valid), .m_ready_i (m_ready),
        .m_status_o (m_status), .m_samples_o (m_samples), .overrun_o (overrun)
    );

    // converter model
    logic [31:0] dev_words [4];
    logic [7:0]  dev_cnt = 8'd0;
    logic [31:0] dev_rx = '0;
    logic [15:0] dev_first = '0;
    bit          dev_nz = 0;
    logic [15:0] cmd_log [64];
    int          words_log [64];
    bit          nz_log [64];
    int          nfr = 0;
    logic [15:0] corrupt_cmd = 16'h4B20;
    bit          corrupt_armed = 1;

    assign miso = (dev_cnt < 8'd128) ? dev_words[dev_cnt[6:5]][5'd31 - dev_cnt[4:0]] : 1'b0;

    function automatic logic [15:0] ack_of(input logic [15:0] c);
        if (c[15:13] == 3'b010) return c ^ 16'h6000;
        return c;
    endfunction

    function automatic logic [31:0] sext(input logic [31:0] w);
        return {{8{w[31]}}, w[31:8]};
    endfunction

    always @(negedge cs_n) begin
        dev_cnt = 8'd0;
        dev_nz  = 0;
    end

    always @(posedge sclk) begin
        if (!cs_n) begin
            dev_rx = {dev_rx[30:0], mosi};
            if (mosi) dev_nz = 1;
            if (dev_cnt == 8'd31) dev_first = dev_rx[31:16];
            dev_cnt = dev_cnt + 8'd1;
        end
    end

    always @(posedge cs_n) begin
        if (dev_cnt != 8'd0 && nfr < 64) begin
            cmd_log[nfr]   = dev_first;
            words_log[nfr] = int'(dev_cnt) / 32;
            nz_log[nfr]    = dev_nz;
            nfr = nfr + 1;
            if (dev_first != 16'h0000) begin
                dev_words[0] = {ack_of(dev_first), 16'h0000};
                if (corrupt_armed && dev_first == corrupt_cmd) begin
                    dev_words[0] = dev_words[0] ^ 32'h0100_0000;
                    corrupt_armed = 0;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_valid();
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (m_valid) break;
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        logic [15:0] exp_cmds [16];
        int n_exp;
        int base;
        logic [15:0] st;
        logic [31:0] w1, w2;
        for (int i = 0; i < 4; i++) dev_words[i] = '0;
        void'($urandom(32'd1234));

        repeat (4) @(negedge clk);
        // R11 reset state
        check(cs_n == 1'b1 && sclk == 1'b0 && !m_valid && !overrun, "R11",
              {cs_n, sclk, m_valid, overrun}, 4'b1000);
        rst_n = 1'b1;

        // R1 / R2 expected startup stream, with one corrupted ack on 0x4B20
        n_exp = 0;
        exp_cmds[n_exp++] = 16'h0655; exp_cmds[n_exp++] = 16'h0000;
        exp_cmds[n_exp++] = 16'h4B20; exp_cmds[n_exp++] = 16'h0000;
        exp_cmds[n_exp++] = 16'h4B20; exp_cmds[n_exp++] = 16'h0000;
        exp_cmds[n_exp++] = 16'h4D02; exp_cmds[n_exp++] = 16'h0000;
        exp_cmds[n_exp++] = 16'h4E80; exp_cmds[n_exp++] = 16'h0000;
        exp_cmds[n_exp++] = 16'h4F0F; exp_cmds[n_exp++] = 16'h0000;
        exp_cmds[n_exp++] = 16'h0033; exp_cmds[n_exp++] = 16'h0000;

        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (nfr >= n_exp) break;
        end
        for (int i = 0; i < n_exp; i++) begin
            check(cmd_log[i] == exp_cmds[i], (i == 4) ? "R2" : "R1", cmd_log[i], exp_cmds[i]);
            check(words_log[i] == 1, "R1", words_log[i], 1);
        end

        // R3: level held low (and edge during startup) starts no frame
        repeat (2000) @(negedge clk);
        check(nfr == n_exp, "R3", nfr, n_exp);
        check(!m_valid, "R3", m_valid, 0);

        // data frames
        for (int k = 0; k < 20; k++) begin
            st = (k % 3 == 0) ? 16'hFF02 : 16'($urandom);
            w1 = $urandom; w2 = $urandom;
            if (k == 1) begin w1 = 32'h8000_00FF; w2 = 32'h7FFF_FF00; end
            if (k == 2) begin w1 = 32'hFFFF_FF12; w2 = 32'h0000_0134; end
            dev_words[0] = {st, 16'($urandom)};
            dev_words[1] = w1;
            dev_words[2] = w2;
            base = nfr;
            drdy_n = 1'b1;
            repeat (6) @(negedge clk);
            drdy_n = 1'b0;
            wait_valid();
            check(m_valid, "R3", m_valid, 1);
            check(m_status == st, "R7", m_status, st);
            check(m_samples[31:0] == sext(w1), "R8", m_samples[31:0], sext(w1));
            check(m_samples[63:32] == sext(w2), "R8", m_samples[63:32], sext(w2));
            check(nfr == base + 1, "R4", nfr, base + 1);
            check(words_log[base] == 3, "R4", words_log[base], 3);
            check(!nz_log[base], "R5", nz_log[base], 0);
            // R9 hold while not ready
            repeat (int'($urandom_range(1, 8))) @(negedge clk);
            check(m_valid && m_status == st, "R9", {m_valid, m_status}, {1'b1, st});
            m_ready = 1'b1;
            @(negedge clk);
            m_ready = 1'b0;
            check(!m_valid, "R9", m_valid, 0);
        end

        // R10 overrun
        check(!overrun, "R10", overrun, 0);
        base = nfr;
        drdy_n = 1'b1;
        repeat (6) @(negedge clk);
        drdy_n = 1'b0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (!cs_n) break;
        end
        repeat (40) @(negedge clk);
        drdy_n = 1'b1;
        repeat (6) @(negedge clk);
        drdy_n = 1'b0;
        wait_valid();
        m_ready = 1'b1;
        @(negedge clk);
        m_ready = 1'b0;
        repeat (1500) @(negedge clk);
        check(overrun, "R10", overrun, 1);
        check(nfr == base + 1, "R10", nfr, base + 1);

        finish_run();
    end
endmodule